// File: doc/BRIEF.md
# Memory Test Data Pattern Source and Verifier

This block supplies the data word for every write beat of a memory-test pass and, on a verify pass, regenerates the same words to compare them with what the memory returns. A pass begins with a one-cycle start pulse. On that pulse the block captures the pattern type and the user constant. It then restarts its sequences, clears the mismatch counter and keeps the captured settings until the next start. Address generation and bus handshaking are left to the surrounding engine. That engine reports accepted write beats and presents read data together with its valid and ready signals.

Write data and expected read data come from two independent generators that share the captured settings. Each advances only on its own kind of accepted beat, so a verify pass reproduces exactly what the write pass produced. The mismatch counter saturates instead of wrapping. The last word received stays visible after the pass ends.

Top module: `mtp_engine`

## Requirements
- R1: After reset, wr_data, err_count and last_rd are all zero, and the captured pattern type is all-zeros.
- R2: pat_sel and user_word are sampled only in a cycle where pass_start is high. Changes to them at any other time have no effect on wr_data or on the expected sequence until the next start.
- R3: Pattern code 0 gives 0x00000000 on every beat and code 1 gives 0xFFFFFFFF on every beat.
- R4: Pattern code 2 gives the captured user_word on every beat.
- R5: Pattern code 3 gives an incrementing byte pattern. Byte lane b (bits 8b+7:8b) of beat k holds (0x11 * (4k + b)) mod 256. Beat 0 is therefore 0x33221100 and beat 1 is 0x77665544, and the pattern restarts at beat 0 on every pass_start.
- R6: The write sequence moves to its next beat one cycle after a cycle with wr_beat high, and holds otherwise. The expected sequence moves only on accepted read beats. Write beats do not move the expected sequence, and read beats do not move the write sequence.
- R7: A read beat is accepted when rd_valid and rd_ready are both high. If rd_data differs from the expected word, err_count rises by one in the next cycle. A matching beat, or a beat that is not accepted, leaves err_count unchanged.
- R8: err_count is cleared by pass_start, and it stays at its all-ones maximum instead of wrapping.
- R9: last_rd takes rd_data in the cycle after each accepted read beat and holds it otherwise, including across pass_start.
- R10: In a cycle with pass_start high, any write beat or read beat presented in the same cycle is ignored. Both sequences start from beat 0, err_count becomes zero and last_rd is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pass_start | input | 1 | One-cycle pulse that begins a pass and captures the settings |
| pat_sel | input | 2 | Pattern type: 0 zeros, 1 ones, 2 user word, 3 incrementing |
| user_word | input | DATA_W | Constant used for pattern type 2 |
| wr_beat | input | 1 | A write beat was accepted this cycle |
| rd_valid | input | 1 | Read data is valid |
| rd_ready | input | 1 | Read data is being taken |
| rd_data | input | DATA_W | Returned read data |
| wr_data | output | DATA_W | Data word for the current write beat |
| err_count | output | ERR_W | Saturating count of mismatching read beats |
| last_rd | output | DATA_W | Last accepted read word |

## Verification
The hardest conditions to reach are counter saturation and the collision of a start pulse with a data beat. A 32-bit counter cannot saturate in a short run. For that reason, a second instance with a 4-bit counter shares the same stimulus and is driven through a long run of corrupted read beats. Start pulses are also placed on purpose in cycles that carry write and read beats, and they occur at random during the constrained-random phase. Settings are changed in the middle of a pass to show that they are not taken up.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [1:0] {
    PAT_ZERO = 2'd0,
    PAT_ONES = 2'd1,
    PAT_USER = 2'd2,
    PAT_INCR = 2'd3
  } pat_e;
endpackage

// File: rtl/mtp_rst_sync.sv
module mtp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mtp_cfg.sv
module mtp_cfg
  import mtp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        sel_in,
  input  logic [DATA_W-1:0] user_in,
  output pat_e              sel_q,
  output logic [DATA_W-1:0] user_q
);
  pat_e              sel_d;
  logic [DATA_W-1:0] user_d;

  always_comb begin
    sel_d  = sel_q;
    user_d = user_q;
    if (start) begin
      sel_d  = pat_e'(sel_in);
      user_d = user_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= PAT_ZERO;
      user_q <= '0;
    end else if (start) begin
      sel_q  <= sel_d;
      user_q <= user_d;
    end
  end

  // R2
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sel_q) && $stable(user_q)));
endmodule

// File: rtl/mtp_seq_gen.sv
module mtp_seq_gen
  import mtp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  pat_e              sel,
  input  logic [DATA_W-1:0] user,
  output logic [DATA_W-1:0] word
);
  localparam int          NB     = DATA_W / 8;
  localparam logic [7:0]  STEP_B = 8'((17 * NB) % 256);

  logic [DATA_W-1:0] seed;
  logic [DATA_W-1:0] bumped;
  logic [DATA_W-1:0] incr_q;
  logic [DATA_W-1:0] incr_d;
  logic              incr_en;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam logic [7:0] SEED_B = 8'((17 * g) % 256);
    assign seed[8*g +: 8]   = SEED_B;
    assign bumped[8*g +: 8] = incr_q[8*g +: 8] + STEP_B;
  end

  assign incr_en = restart | advance;

  always_comb begin
    incr_d = incr_q;
    if (restart)      incr_d = seed;
    else if (advance) incr_d = bumped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       incr_q <= seed;
    else if (incr_en) incr_q <= incr_d;
  end

  always_comb begin
    case (sel)
      PAT_ZERO: word = '0;
      PAT_ONES: word = '1;
      PAT_USER: word = user;
      default:  word = incr_q;
    endcase
  end

  // R5
  incr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (incr_q == seed));

  // R6
  incr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(incr_q));

  // R3
  always_comb begin
    if (rst_n && sel == PAT_ONES) ones_word_chk: assert (word == '1);
  end
endmodule

// File: rtl/mtp_check.sv
module mtp_check #(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] expected,
  output logic [ERR_W-1:0]  err_q,
  output logic [DATA_W-1:0] last_q
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [ERR_W-1:0] ERR_ONE = ERR_W'(1);

  logic [ERR_W-1:0]  err_d;
  logic [DATA_W-1:0] last_d;
  logic              mismatch;
  logic              err_en;
  logic              last_en;

  assign mismatch = (rd_data != expected);
  assign err_en   = clear | beat;
  assign last_en  = beat & ~clear;

  always_comb begin
    err_d  = err_q;
    last_d = last_q;
    if (clear) begin
      err_d = '0;
    end else if (beat) begin
      last_d = rd_data;
      if (mismatch && err_q != ERR_MAX) err_d = err_q + ERR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (last_en) last_q <= last_d;
  end

  // R8
  err_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && err_q == ERR_MAX) |=> (err_q == ERR_MAX));

  // R7
  err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_q >= $past(err_q)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !beat) |=> ($stable(err_q) && $stable(last_q)));
endmodule

// File: rtl/mtp_engine.sv
module mtp_engine
  import mtp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_start,
  input  logic [1:0]        pat_sel,
  input  logic [DATA_W-1:0] user_word,
  input  logic              wr_beat,
  input  logic              rd_valid,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_data,
  output logic [ERR_W-1:0]  err_count,
  output logic [DATA_W-1:0] last_rd
);
  logic              rst_s_n;
  pat_e              sel_q;
  logic [DATA_W-1:0] user_q;
  logic [DATA_W-1:0] exp_word;
  logic              wr_adv;
  logic              rd_acc;

  assign wr_adv = wr_beat & ~pass_start;
  assign rd_acc = rd_valid & rd_ready & ~pass_start;

  mtp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  mtp_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (pass_start),
    .sel_in  (pat_sel),
    .user_in (user_word),
    .sel_q   (sel_q),
    .user_q  (user_q)
  );

  mtp_seq_gen #(.DATA_W(DATA_W)) u_wr_gen (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (pass_start),
    .advance (wr_adv),
    .sel     (sel_q),
    .user    (user_q),
    .word    (wr_data)
  );

  mtp_seq_gen #(.DATA_W(DATA_W)) u_exp_gen (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (pass_start),
    .advance (rd_acc),
    .sel     (sel_q),
    .user    (user_q),
    .word    (exp_word)
  );

  mtp_check #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clear    (pass_start),
    .beat     (rd_acc),
    .rd_data  (rd_data),
    .expected (exp_word),
    .err_q    (err_count),
    .last_q   (last_rd)
  );

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    pass_start |=> (err_count == '0));
endmodule

// File: tb/sim_mtp_engine.sv
module sim_mtp_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ps = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [31:0] uw = 32'd0;
  logic        wb = 1'b0;
  logic        rv = 1'b0;
  logic        rr = 1'b0;
  logic [31:0] rd = 32'd0;
  logic [31:0] wr_data;
  logic [31:0] err_count;
  logic [31:0] last_rd;
  logic [31:0] wr_data_s;
  logic [3:0]  err_s;
  logic [31:0] last_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_sel = 0;
  logic [31:0] m_user = 0;
  int          m_wk = 0;
  int          m_rk = 0;
  longint      m_err = 0;
  int          m_err_sat = 0;
  logic [31:0] m_last = 0;

  always #5 clk = ~clk;

  mtp_engine u0 (
    .clk(clk), .rst_n(rst_n), .pass_start(ps), .pat_sel(sel_i), .user_word(uw),
    .wr_beat(wb), .rd_valid(rv), .rd_ready(rr), .rd_data(rd),
    .wr_data(wr_data), .err_count(err_count), .last_rd(last_rd));

  mtp_engine #(.DATA_W(32), .ERR_W(4)) u_sat (
    .clk(clk), .rst_n(rst_n), .pass_start(ps), .pat_sel(sel_i), .user_word(uw),
    .wr_beat(wb), .rd_valid(rv), .rd_ready(rr), .rd_data(rd),
    .wr_data(wr_data_s), .err_count(err_s), .last_rd(last_s));

  function automatic logic [31:0] pat(int s, logic [31:0] u, int k);
    logic [31:0] w;
    case (s)
      0: w = 32'h0;
      1: w = 32'hFFFF_FFFF;
      2: w = u;
      default: for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'((17 * (4 * k + b)) % 256);
    endcase
    return w;
  endfunction

  function automatic string sel_tag(int s);
    if (s == 2) return "R4";
    if (s == 3) return "R5";
    return "R3";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_update();
    if (ps) begin
      m_sel = int'(sel_i); m_user = uw; m_wk = 0; m_rk = 0; m_err = 0; m_err_sat = 0;
    end else begin
      if (wb) m_wk++;
      if (rv && rr) begin
        if (rd != pat(m_sel, m_user, m_rk)) begin
          if (m_err < 64'hFFFF_FFFF) m_err++;
          if (m_err_sat < 15) m_err_sat++;
        end
        m_rk++;
        m_last = rd;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(sel_tag(m_sel), wr_data, pat(m_sel, m_user, m_wk));
    check("R7", err_count, 32'(m_err));
    check("R8", {28'd0, err_s}, 32'(m_err_sat));
    check("R9", last_rd, m_last);
  endtask

  task automatic idle();
    ps = 0; wb = 0; rv = 0; rr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", wr_data, 32'h0);
    check("R1", err_count, 32'h0);
    check("R1", last_rd, 32'h0);

    // R5 incrementing sequence, R6 hold without beat
    ps = 1; sel_i = 2'd3; tick();
    idle();
    check("R5", wr_data, 32'h3322_1100);
    wb = 1; tick();
    check("R5", wr_data, 32'h7766_5544);
    wb = 0; tick(); tick();
    check("R6", wr_data, 32'h7766_5544);
    // R2 settings changed mid-pass are ignored
    sel_i = 2'd1; uw = 32'hDEAD_BEEF; wb = 1; tick();
    check("R2", wr_data, 32'hBBAA_9988);
    wb = 0;
    // R6 read beats advance only expected sequence
    rv = 1; rr = 1; rd = 32'h3322_1100; tick();
    rd = 32'h7766_5544; tick();
    rv = 0; rr = 0;
    check("R6", wr_data, 32'hBBAA_9988);
    check("R7", err_count, 32'h0);
    rv = 1; rr = 0; rd = 32'h1; tick();
    check("R7", err_count, 32'h0);
    rr = 1; rd = 32'h1; tick();
    check("R7", err_count, 32'h1);
    check("R9", last_rd, 32'h1);
    idle();

    // R10 start collides with beats
    ps = 1; sel_i = 2'd3; wb = 1; rv = 1; rr = 1; rd = 32'hABCD_0123; tick();
    idle();
    check("R10", wr_data, 32'h3322_1100);
    check("R10", err_count, 32'h0);
    check("R10", last_rd, 32'h1);

    // R8 saturation on the narrow counter
    ps = 1; sel_i = 2'd0; tick();
    idle();
    rv = 1; rr = 1; rd = 32'hFFFF_FFFF;
    repeat (20) tick();
    idle(); tick();
    check("R8", {28'd0, err_s}, 32'd15);
    check("R7", err_count, 32'd20);
    ps = 1; sel_i = 2'd2; uw = 32'h5555_AAAA; tick();
    idle();
    check("R8", {28'd0, err_s}, 32'd0);
    check("R4", wr_data, 32'h5555_AAAA);
    check("R9", last_rd, 32'hFFFF_FFFF);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      ps = ($urandom % 64) == 0;
      sel_i = 2'($urandom % 4);
      if (($urandom % 8) == 0) uw = $urandom;
      wb = ($urandom % 2) == 0;
      rv = ($urandom % 4) != 0;
      rr = ($urandom % 4) != 0;
      rd = (($urandom % 6) == 0) ? $urandom : pat(m_sel, m_user, m_rk);
      tick();
    end
    idle(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule